// File: doc/BRIEF.md
# Multiplexed LCD COM/SEG Sequencer

This block produces the time-multiplexed drive pattern for a segment LCD. A free-running reference tick at 32768 Hz is divided down to a step clock. Each frame is one pass over the active commons with positive polarity, then a second pass with inverted polarity, so that every pixel sees zero net DC. For every common and segment pin the block outputs a 2-bit level code. The analog side turns that code into a pad voltage: 00 = ground, 01 = lower intermediate rail (1/3 of full in 1/3 bias, 1/2 of full in 1/2 bias), 10 = upper intermediate rail (2/3 of full), 11 = top rail.

Configuration is taken from plain inputs: an enable, a clock-rate select, a mode field that sets both the multiplex depth and the bias, and a 4-bit pixel word and 4-bit blink mask per segment. A per-pin select hands any segment pin over to general digital I/O. Mode and rate are captured only at frame boundaries, so a frame is never cut short. A blink phase flips every 32 frames. While it is in its hidden half, pixels whose blink bit is set are shown as off.

The controller is a three-state machine. OFF is the reset state and the state while the display is disabled. POS is the positive half of a frame and NEG is the inverted half. The transitions are:
- START: OFF to POS when the enable goes high.
- ADVANCE: POS to POS and NEG to NEG on a step while further commons remain.
- FLIP: POS to NEG after the last active common.
- WRAP: NEG to POS after the last active common. WRAP marks the frame boundary, where mode and rate are reloaded.
- STOP: POS or NEG to OFF when the enable goes low.

Top module: `lcd_mux_seq`

## Requirements
- R1: The step period in reference ticks is 512, 256, 128 or 64 for `cfg_clk_sel` 00, 01, 10, 11. `step_strobe` pulses once per period.
- R2: Mode codes set the number of active commons: 000 = 4, 001 = 3, 010 = 2, 011 = 3, 100 = 1. Codes 101, 110 and 111 behave as 100. One frame contains twice that many steps.
- R3: A common whose index is at or above the active count stays at 00.
- R4: Drive levels follow the bias of the mode. Modes 000 and 001 use 1/3 bias, 010 and 011 use 1/2 bias, and 100 and up use static drive.
  - Selected common: 11 in POS, 00 in NEG.
  - Unselected common: 01 in POS and 10 in NEG for 1/3 bias; 01 in both halves for 1/2 bias.
  - On segment: 00 in POS, 11 in NEG.
  - Off segment: 10 in POS and 01 in NEG for 1/3 bias; 01 for 1/2 bias; equal to the common's level for static drive.
  - As a result, every active common/segment pair sums to zero over a frame.
- R5: One clock after `cfg_en` is sampled low, all COM and SEG levels and both `rail_en` bits are 0.
- R6: The blink phase becomes hidden on the 33rd frame after enabling and flips every 32 frames after that. It changes only at a frame boundary. While the phase is hidden, a pixel whose blink bit is set is driven as off. Bit c of a segment's pixel and blink words belongs to common c, so bit 3 is COM3 and bit 0 is COM0.
- R7: A pin whose `seg_is_lcd` bit is 0 outputs level 00 and raises its `seg_released` bit. This holds whether or not the display is enabled.
- R8: Changes to `cfg_mode` or `cfg_clk_sel` during a frame take effect only from the next frame. `frame_sync` marks the first cycle of each frame.
- R9: After reset with all configuration at zero, no step or frame pulse occurs, all levels are 00, and every pin reports released.
- R10: Within each half-frame the commons are selected one per step, in order from COM0 upward. The POS half comes before the NEG half. `rail_en` is 11 for 1/3 bias, 01 for 1/2 bias and 00 for static drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ref | input | 1 | One-cycle pulse per 32768 Hz reference period |
| cfg_en | input | 1 | Display enable |
| cfg_clk_sel | input | 2 | Step-rate select |
| cfg_mode | input | 3 | Multiplex/bias mode |
| seg_pixels | input | N_SEG*4 | Pixel word per segment, bit c = common c |
| seg_blink | input | N_SEG*4 | Blink mask per segment, bit c = common c |
| seg_is_lcd | input | N_SEG | 1 = LCD segment, 0 = general I/O |
| com_lvl | output | 8 | Level code for each of the four commons |
| seg_lvl | output | N_SEG*2 | Level code for each segment pin |
| seg_released | output | N_SEG | Pin handed over to general I/O |
| rail_en | output | 2 | Enables for the lower and upper intermediate rails |
| step_strobe | output | 1 | Pulse in the last cycle of each step |
| frame_sync | output | 1 | Pulse in the first cycle of each frame |

## Verification
The hardest case to reach from the ports is the second blink phase. It shows up only after 32 complete frames without interruption, and any disable in between resets the blink counter. The bench holds the reference tick high every cycle and uses the fastest step rate in four-common mode. It then counts `frame_sync` pulses and compares the levels of frames 31 and 32 against a model that applies the hidden mask only to COM3. A second hard case is a mode and rate change part-way through a frame. The bench makes that change just after the first step strobe, then checks that the remaining step count and the step period still follow the old setting.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    localparam int N_COM    = 4;
    localparam int LVL_W    = 2;
    localparam int MODE_W   = 3;
    localparam int SEL_W    = 2;
    localparam int NCOM_W   = 3;
    localparam int IDX_W    = 2;

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_POS = 2'd1,
        ST_NEG = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        BIAS_THIRD  = 2'd0,
        BIAS_HALF   = 2'd1,
        BIAS_STATIC = 2'd2
    } bias_t;

    typedef enum logic [LVL_W-1:0] {
        LVL_GND  = 2'b00,
        LVL_LOW  = 2'b01,
        LVL_HIGH = 2'b10,
        LVL_TOP  = 2'b11
    } lvl_t;

    function automatic logic [NCOM_W-1:0] mode_commons(input logic [MODE_W-1:0] m);
        logic [NCOM_W-1:0] n;
        case (m)
            3'b000:  n = 3'd4;
            3'b001:  n = 3'd3;
            3'b010:  n = 3'd2;
            3'b011:  n = 3'd3;
            default: n = 3'd1;
        endcase
        return n;
    endfunction

    function automatic bias_t mode_bias(input logic [MODE_W-1:0] m);
        bias_t b;
        case (m)
            3'b000, 3'b001: b = BIAS_THIRD;
            3'b010, 3'b011: b = BIAS_HALF;
            default:        b = BIAS_STATIC;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lcd_step_div.sv
module lcd_step_div
    import lcd_seq_pkg::*;
#(
    parameter int MIN_LOG2 = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             step
);

    localparam int MAX_LOG2 = MIN_LOG2 + (2**SEL_W) - 1;
    localparam int CNT_W    = MAX_LOG2;
    localparam int LIM_W    = MAX_LOG2 + 1;
    localparam int SHAMT_W  = $clog2(MAX_LOG2 + 1);

    logic [CNT_W-1:0]   cnt_q;
    logic [SHAMT_W-1:0] shamt;
    logic [LIM_W-1:0]   lim_w;
    logic [CNT_W-1:0]   lim;

    // Faster rate for larger select: period = 2^(MAX_LOG2 - sel)
    always_comb begin
        shamt = SHAMT_W'(MAX_LOG2) - SHAMT_W'(sel);
        lim_w = (LIM_W'(1) << shamt) - LIM_W'(1);
        lim   = lim_w[CNT_W-1:0];
    end

    assign step = run && tick && (cnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == lim) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/lcd_frame_fsm.sv
module lcd_frame_fsm
    import lcd_seq_pkg::*;
#(
    parameter int BLINK_FRAMES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic              step,
    output seq_state_t        state,
    output logic [IDX_W-1:0]  com_idx,
    output logic [MODE_W-1:0] act_mode,
    output logic [SEL_W-1:0]  act_sel,
    output logic [NCOM_W-1:0] act_ncom,
    output bias_t             act_bias,
    output logic              frame_sync,
    output logic              blink_hide
);

    localparam int BL_W = (BLINK_FRAMES > 1) ? $clog2(BLINK_FRAMES) : 1;

    seq_state_t        state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [MODE_W-1:0] mode_q, mode_d;
    logic [SEL_W-1:0]  sel_q, sel_d;
    logic              sync_q, sync_d;
    logic [BL_W-1:0]   bcnt_q, bcnt_d;
    logic              hide_q, hide_d;
    logic              last_com;
    logic              frame_end;

    assign act_ncom = mode_commons(mode_q);
    assign act_bias = mode_bias(mode_q);
    assign last_com = ({1'b0, idx_q} == (act_ncom - NCOM_W'(1)));

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            idx_q   <= '0;
            mode_q  <= '0;
            sel_q   <= '0;
            sync_q  <= 1'b0;
            bcnt_q  <= '0;
            hide_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            mode_q  <= mode_d;
            sel_q   <= sel_d;
            sync_q  <= sync_d;
            bcnt_q  <= bcnt_d;
            hide_q  <= hide_d;
        end
    end

    // Transition process
    always_comb begin
        state_d   = state_q;
        idx_d     = idx_q;
        mode_d    = mode_q;
        sel_d     = sel_q;
        sync_d    = 1'b0;
        frame_end = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (en) begin                      // START
                    state_d = ST_POS;
                    idx_d   = '0;
                    mode_d  = cfg_mode;
                    sel_d   = cfg_sel;
                    sync_d  = 1'b1;
                end
            end
            ST_POS: begin
                if (!en) begin                     // STOP
                    state_d = ST_OFF;
                    idx_d   = '0;
                end else if (step) begin
                    if (last_com) begin            // FLIP
                        state_d = ST_NEG;
                        idx_d   = '0;
                    end else begin                 // ADVANCE
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
            end
            ST_NEG: begin
                if (!en) begin                     // STOP
                    state_d = ST_OFF;
                    idx_d   = '0;
                end else if (step) begin
                    if (last_com) begin            // WRAP
                        state_d   = ST_POS;
                        idx_d     = '0;
                        mode_d    = cfg_mode;
                        sel_d     = cfg_sel;
                        sync_d    = 1'b1;
                        frame_end = 1'b1;
                    end else begin                 // ADVANCE
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
            end
            default: begin
                state_d = ST_OFF;
                idx_d   = '0;
            end
        endcase
    end

    // Blink phase bookkeeping, changes only on a frame wrap or a stop
    always_comb begin
        bcnt_d = bcnt_q;
        hide_d = hide_q;
        if (!en || state_q == ST_OFF) begin
            bcnt_d = '0;
            hide_d = 1'b0;
        end else if (frame_end) begin
            if (bcnt_q == BL_W'(BLINK_FRAMES - 1)) begin
                bcnt_d = '0;
                hide_d = !hide_q;
            end else begin
                bcnt_d = bcnt_q + BL_W'(1);
            end
        end
    end

    // Output process
    always_comb begin
        state      = state_q;
        com_idx    = idx_q;
        act_mode   = mode_q;
        act_sel    = sel_q;
        frame_sync = sync_q;
        blink_hide = hide_q;
    end

endmodule

// File: rtl/lcd_drive_map.sv
module lcd_drive_map
    import lcd_seq_pkg::*;
#(
    parameter int N_SEG = 8
) (
    input  seq_state_t               state,
    input  logic [IDX_W-1:0]         com_idx,
    input  logic [NCOM_W-1:0]        ncom,
    input  bias_t                    bias,
    input  logic                     hide,
    input  logic [N_SEG*N_COM-1:0]   pixels,
    input  logic [N_SEG*N_COM-1:0]   blink,
    input  logic [N_SEG-1:0]         is_lcd,
    output logic [N_COM*LVL_W-1:0]   com_lvl,
    output logic [N_SEG*LVL_W-1:0]   seg_lvl,
    output logic [N_SEG-1:0]         released,
    output logic [1:0]               rail_en
);

    logic on;
    logic neg;

    assign on  = (state != ST_OFF);
    assign neg = (state == ST_NEG);

    always_comb begin
        if (!on) begin
            rail_en = 2'b00;
        end else begin
            unique case (bias)
                BIAS_THIRD: rail_en = 2'b11;
                BIAS_HALF:  rail_en = 2'b01;
                default:    rail_en = 2'b00;
            endcase
        end
    end

    for (genvar j = 0; j < N_COM; j++) begin : g_com
        logic active;
        logic picked;
        lvl_t lvl;
        assign active = (NCOM_W'(j) < ncom);
        assign picked = (com_idx == IDX_W'(j));
        always_comb begin
            if (!on || !active) begin
                lvl = LVL_GND;
            end else if (picked) begin
                lvl = neg ? LVL_GND : LVL_TOP;
            end else begin
                unique case (bias)
                    BIAS_THIRD: lvl = neg ? LVL_HIGH : LVL_LOW;
                    BIAS_HALF:  lvl = LVL_LOW;
                    default:    lvl = LVL_GND;
                endcase
            end
        end
        assign com_lvl[j*LVL_W +: LVL_W] = lvl;
    end

    for (genvar s = 0; s < N_SEG; s++) begin : g_seg
        logic [N_COM-1:0] pix_w;
        logic [N_COM-1:0] blk_w;
        logic             lit;
        lvl_t             lvl;
        assign pix_w = pixels[s*N_COM +: N_COM];
        assign blk_w = blink[s*N_COM +: N_COM];
        assign lit   = pix_w[com_idx] && !(blk_w[com_idx] && hide);
        always_comb begin
            if (!is_lcd[s] || !on) begin
                lvl = LVL_GND;
            end else if (lit) begin
                lvl = neg ? LVL_TOP : LVL_GND;
            end else begin
                unique case (bias)
                    BIAS_THIRD: lvl = neg ? LVL_LOW : LVL_HIGH;
                    BIAS_HALF:  lvl = LVL_LOW;
                    default:    lvl = neg ? LVL_GND : LVL_TOP;
                endcase
            end
        end
        assign seg_lvl[s*LVL_W +: LVL_W] = lvl;
        assign released[s] = !is_lcd[s];
    end

endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq
    import lcd_seq_pkg::*;
#(
    parameter int N_SEG        = 8,
    parameter int BLINK_FRAMES = 32,
    parameter int DIV_MIN_LOG2 = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick_ref,
    input  logic                     cfg_en,
    input  logic [1:0]               cfg_clk_sel,
    input  logic [2:0]               cfg_mode,
    input  logic [N_SEG*4-1:0]       seg_pixels,
    input  logic [N_SEG*4-1:0]       seg_blink,
    input  logic [N_SEG-1:0]         seg_is_lcd,
    output logic [7:0]               com_lvl,
    output logic [N_SEG*2-1:0]       seg_lvl,
    output logic [N_SEG-1:0]         seg_released,
    output logic [1:0]               rail_en,
    output logic                     step_strobe,
    output logic                     frame_sync
);

    seq_state_t        state;
    logic [IDX_W-1:0]  com_idx;
    logic [MODE_W-1:0] act_mode;
    logic [SEL_W-1:0]  act_sel;
    logic [NCOM_W-1:0] act_ncom;
    bias_t             act_bias;
    logic              blink_hide;
    logic              run;

    assign run = (state != ST_OFF);

    lcd_step_div #(
        .MIN_LOG2 (DIV_MIN_LOG2)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick_ref),
        .sel   (act_sel),
        .step  (step_strobe)
    );

    lcd_frame_fsm #(
        .BLINK_FRAMES (BLINK_FRAMES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cfg_en),
        .cfg_mode   (cfg_mode),
        .cfg_sel    (cfg_clk_sel),
        .step       (step_strobe),
        .state      (state),
        .com_idx    (com_idx),
        .act_mode   (act_mode),
        .act_sel    (act_sel),
        .act_ncom   (act_ncom),
        .act_bias   (act_bias),
        .frame_sync (frame_sync),
        .blink_hide (blink_hide)
    );

    lcd_drive_map #(
        .N_SEG (N_SEG)
    ) u_map (
        .state    (state),
        .com_idx  (com_idx),
        .ncom     (act_ncom),
        .bias     (act_bias),
        .hide     (blink_hide),
        .pixels   (seg_pixels),
        .blink    (seg_blink),
        .is_lcd   (seg_is_lcd),
        .com_lvl  (com_lvl),
        .seg_lvl  (seg_lvl),
        .released (seg_released),
        .rail_en  (rail_en)
    );

endmodule

// File: rtl/lcd_mux_seq_chk.sv
module lcd_mux_seq_chk #(
    parameter int N_SEG = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_en,
    input logic [7:0]         com_lvl,
    input logic [N_SEG*2-1:0] seg_lvl,
    input logic [N_SEG-1:0]   seg_released,
    input logic [1:0]         rail_en,
    input logic               step_strobe,
    input logic               frame_sync,
    input logic [2:0]         act_mode,
    input logic [2:0]         act_ncom,
    input logic               blink_hide
);

    logic [4:0] steps_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            steps_seen <= '0;
        end else if (frame_sync) begin
            steps_seen <= '0;
        end else if (step_strobe && steps_seen != 5'd31) begin
            steps_seen <= steps_seen + 5'd1;
        end
    end

    AST_FRAME_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        steps_seen <= 5'd8); // R2

    AST_UNUSED_COM3_GND: assert property (@(posedge clk) disable iff (!rst_n)
        (act_ncom < 3'd4) |-> (com_lvl[7:6] == 2'b00)); // R3

    AST_UNUSED_COM1_GND: assert property (@(posedge clk) disable iff (!rst_n)
        (act_ncom < 3'd2) |-> (com_lvl[3:2] == 2'b00)); // R3

    AST_OFF_COM_GND: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (com_lvl == 8'h00 && rail_en == 2'b00)); // R5

    AST_OFF_SEG_GND: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (seg_lvl == '0)); // R5

    AST_BLINK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(blink_hide) && $past(cfg_en)) |-> frame_sync); // R6

    AST_MODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_mode) |-> frame_sync); // R8

    for (genvar s = 0; s < N_SEG; s++) begin : g_rel
        AST_RELEASED_GND: assert property (@(posedge clk) disable iff (!rst_n)
            seg_released[s] |-> (seg_lvl[s*2 +: 2] == 2'b00)); // R7
    end

endmodule

bind lcd_mux_seq lcd_mux_seq_chk #(
    .N_SEG (N_SEG)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_en       (cfg_en),
    .com_lvl      (com_lvl),
    .seg_lvl      (seg_lvl),
    .seg_released (seg_released),
    .rail_en      (rail_en),
    .step_strobe  (step_strobe),
    .frame_sync   (frame_sync),
    .act_mode     (act_mode),
    .act_ncom     (act_ncom),
    .blink_hide   (blink_hide)
);

// File: tb/sim_lcd_mux_seq.sv
`timescale 1ns/1ps
module sim_lcd_mux_seq;

    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_ref = 1'b1;
    logic          cfg_en = 1'b0;
    logic [1:0]    cfg_clk_sel = '0;
    logic [2:0]    cfg_mode = '0;
    logic [NS*4-1:0] seg_pixels = '0;
    logic [NS*4-1:0] seg_blink = '0;
    logic [NS-1:0] seg_is_lcd = '0;
    logic [7:0]    com_lvl;
    logic [NS*2-1:0] seg_lvl;
    logic [NS-1:0] seg_released;
    logic [1:0]    rail_en;
    logic          step_strobe;
    logic          frame_sync;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    lcd_mux_seq #(.N_SEG(NS)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_ref(tick_ref), .cfg_en(cfg_en),
        .cfg_clk_sel(cfg_clk_sel), .cfg_mode(cfg_mode), .seg_pixels(seg_pixels),
        .seg_blink(seg_blink), .seg_is_lcd(seg_is_lcd), .com_lvl(com_lvl),
        .seg_lvl(seg_lvl), .seg_released(seg_released), .rail_en(rail_en),
        .step_strobe(step_strobe), .frame_sync(frame_sync)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ncom_of(input logic [2:0] m);
        case (m)
            3'b000: return 4;
            3'b001: return 3;
            3'b010: return 2;
            3'b011: return 3;
            default: return 1;
        endcase
    endfunction

    // 0 = third, 1 = half, 2 = static
    function automatic int bias_of(input logic [2:0] m);
        case (m)
            3'b000, 3'b001: return 0;
            3'b010, 3'b011: return 1;
            default: return 2;
        endcase
    endfunction

    function automatic logic [1:0] exp_com(input int j, input bit neg, input int idx,
                                           input int bs, input int nc);
        if (j >= nc) return 2'b00;
        if (j == idx) return neg ? 2'b00 : 2'b11;
        if (bs == 0) return neg ? 2'b10 : 2'b01;
        return 2'b01;
    endfunction

    function automatic logic [1:0] exp_seg(input bit lit, input bit neg, input int bs);
        if (lit) return neg ? 2'b11 : 2'b00;
        if (bs == 0) return neg ? 2'b01 : 2'b10;
        if (bs == 1) return 2'b01;
        return neg ? 2'b00 : 2'b11;
    endfunction

    function automatic int volt(input logic [1:0] c, input int bs);
        if (bs == 0) return int'(c);
        if (bs == 1) return (c == 2'b11) ? 2 : ((c == 2'b00) ? 0 : 1);
        return (c == 2'b11) ? 1 : 0;
    endfunction

    task automatic wait_sync();
        do @(negedge clk); while (!frame_sync);
    endtask

    task automatic wait_strobe();
        do @(negedge clk); while (!step_strobe);
    endtask

    // Call at a negedge where frame_sync is high; checks one full frame
    task automatic measure_frame(input logic [2:0] mode, input bit hide, input string tag);
        int nc = ncom_of(mode);
        int bs = bias_of(mode);
        int dc [4][NS];
        int k = 0;
        bit done = 0;
        bit dc_ok = 1;
        logic [1:0] exp_rail;
        for (int j = 0; j < 4; j++) for (int s = 0; s < NS; s++) dc[j][s] = 0;
        exp_rail = (bs == 0) ? 2'b11 : ((bs == 1) ? 2'b01 : 2'b00);
        chk(rail_en == exp_rail, {tag, " R10 rail_en"}, int'(rail_en), int'(exp_rail));
        while (!done && k < 16) begin
            bit neg = (k >= nc);
            int idx = k % nc;
            bit bad = 0;
            int a = 0;
            int e = 0;
            for (int j = 0; j < 4; j++) begin
                logic [1:0] ec = exp_com(j, neg, idx, bs, nc);
                if (com_lvl[j*2 +: 2] !== ec && !bad) begin
                    bad = 1; a = int'(com_lvl[j*2 +: 2]); e = int'(ec);
                end
            end
            for (int s = 0; s < NS; s++) begin
                logic [1:0] es;
                bit lit = seg_pixels[s*4 + idx] && !(seg_blink[s*4 + idx] && hide);
                es = seg_is_lcd[s] ? exp_seg(lit, neg, bs) : 2'b00;
                if (seg_lvl[s*2 +: 2] !== es && !bad) begin
                    bad = 1; a = int'(seg_lvl[s*2 +: 2]); e = int'(es);
                end
                if (seg_is_lcd[s])
                    for (int j = 0; j < nc; j++)
                        dc[j][s] += volt(com_lvl[j*2 +: 2], bs) - volt(seg_lvl[s*2 +: 2], bs);
            end
            chk(!bad, {tag, " R4 R10 step levels"}, a, e);
            wait_strobe();
            @(negedge clk);
            k++;
            if (frame_sync) done = 1;
        end
        chk(k == 2*nc, {tag, " R2 steps per frame"}, k, 2*nc);
        for (int j = 0; j < nc; j++) for (int s = 0; s < NS; s++)
            if (seg_is_lcd[s] && dc[j][s] != 0) dc_ok = 0;
        chk(dc_ok, {tag, " R4 DC balance"}, dc_ok ? 0 : 1, 0);
    endtask

    task automatic stop_display();
        @(negedge clk);
        cfg_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (step_strobe || frame_sync || com_lvl != 0 || seg_lvl != 0 || rail_en != 0) begin
                chk(0, "R9 quiet after reset", int'(com_lvl), 0);
                break;
            end
        end
        chk(com_lvl == 8'h00, "R9 com levels", int'(com_lvl), 0);
        chk(seg_lvl == '0, "R9 seg levels", int'(seg_lvl), 0);
        chk(seg_released == '1, "R9 all released", int'(seg_released), (1 << NS) - 1);
        chk(rail_en == 2'b00, "R9 rails", int'(rail_en), 0);
    endtask

    task automatic t_divider();
        for (int sel = 0; sel < 4; sel++) begin
            int n = 0;
            cfg_mode = 3'b000;
            cfg_clk_sel = 2'(sel);
            cfg_en = 1'b1;
            wait_sync();
            wait_strobe();
            do begin @(negedge clk); n++; end while (!step_strobe);
            chk(n == (512 >> sel), "R1 step period", n, 512 >> sel);
            stop_display();
        end
    endtask

    task automatic t_modes();
        seg_is_lcd = '1;
        cfg_clk_sel = 2'b11;
        for (int m = 0; m < 8; m++) begin
            seg_pixels = 32'hA5C3_1E96 ^ (32'h1111_1111 * m);
            seg_blink = 32'hFFFF_FFFF;
            cfg_mode = 3'(m);
            cfg_en = 1'b1;
            wait_sync();
            measure_frame(3'(m), 1'b0, $sformatf("mode%0d R3", m));
            stop_display();
        end
        seg_blink = '0;
    endtask

    task automatic t_disable();
        cfg_mode = 3'b000;
        cfg_en = 1'b1;
        wait_sync();
        wait_strobe();
        cfg_en = 1'b0;
        @(negedge clk);
        chk(com_lvl == 8'h00, "R5 com ground", int'(com_lvl), 0);
        chk(seg_lvl == '0, "R5 seg ground", int'(seg_lvl), 0);
        chk(rail_en == 2'b00, "R5 rails off", int'(rail_en), 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_release();
        seg_is_lcd = 8'b0101_0101;
        seg_pixels = '0;
        cfg_mode = 3'b000;
        cfg_en = 1'b1;
        wait_sync();
        chk(seg_released == 8'b1010_1010, "R7 released flags", int'(seg_released), 8'hAA);
        chk(seg_lvl == 16'h2222, "R7 released pins ground", int'(seg_lvl), 16'h2222);
        measure_frame(3'b000, 1'b0, "R7 frame");
        stop_display();
        chk(seg_released == 8'b1010_1010, "R7 flags while off", int'(seg_released), 8'hAA);
        seg_is_lcd = '1;
    endtask

    task automatic t_boundary();
        int n = 0;
        int k = 1;
        cfg_mode = 3'b000;
        cfg_clk_sel = 2'b11;
        cfg_en = 1'b1;
        wait_sync();
        wait_strobe();
        cfg_mode = 3'b100;
        cfg_clk_sel = 2'b00;
        do begin @(negedge clk); n++; end while (!step_strobe);
        chk(n == 64, "R8 period held mid-frame", n, 64);
        k = 2;
        while (k < 20) begin
            @(negedge clk);
            if (frame_sync) break;
            if (step_strobe) k++;
        end
        chk(k == 8, "R8 old frame length kept", k, 8);
        measure_frame(3'b100, 1'b0, "R8 new mode");
        stop_display();
    endtask

    task automatic t_blink();
        int f = 0;
        seg_is_lcd = '1;
        seg_pixels = '1;
        seg_blink = '0;
        seg_blink[3:0] = 4'b1000;
        cfg_mode = 3'b000;
        cfg_clk_sel = 2'b11;
        cfg_en = 1'b1;
        wait_sync();
        while (f < 31) begin
            wait_sync();
            f++;
        end
        measure_frame(3'b000, 1'b0, "R6 frame31 visible");
        measure_frame(3'b000, 1'b1, "R6 frame32 hidden COM3");
        stop_display();
        seg_blink = '0;
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        chk(0, "watchdog", cycles, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_divider();
        t_modes();
        t_disable();
        t_release();
        t_boundary();
        t_blink();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule